// File: doc/BRIEF.md
# Controller power-up reset sequencer

This block brings a serial-link controller out of a cold start. After a `start` pulse it walks through a fixed chain of reset releases and clock-gate enables. It stalls at two handshake points until a power-management request input drops. It then fires one pulse on the application-domain reset, releases the register-domain resets and the peripheral reset, waits a settle time and raises `done_o` together with the link-training enable. All timing counts a one-microsecond strobe `us_tick`, and every delay is a parameter, so a simulation can shorten it.

A handshake that does not clear within the timeout makes the block undo every step already taken, one step per clock and newest first, and then raise `err_o`. A `stop` pulse drops everything at once: link training off, all core resets asserted, both clock groups gated, the peripheral reset asserted. The block then holds that state for a parameterised time before it accepts a new `start`. The application reset is a trigger, so neither the stop path nor the unwind path ever drives it.

Internally a progress level from 0 to 10 records how many steps are complete, and every output decodes from that level. The states are:
- `S_IDLE`: waits for `start`.
- `S_STEP`: advances the level by one step per clock.
- `S_WAIT_PHY` and `S_WAIT_CORE`: the handshake waits.
- `S_APP_PULSE`: the one-cycle application reset.
- `S_SETTLE`: the final delay.
- `S_READY`: bring-up complete.
- `S_UNWIND`: walks the level back down.
- `S_FAIL`: sticky error.
- `S_STOP`: the shutdown hold.

The transitions are:
- idle to step on `start`.
- step to a wait at levels 2 and 5, to the pulse at level 7, and to settle at level 10.
- a wait back to step when a tick sees the request low.
- a wait to unwind on timeout.
- pulse to step.
- settle to ready when the settle time expires.
- unwind to fail at level 0.
- stop to idle when the hold expires.
- any state except stop to stop on `stop`.

Top module: `pwrup_rst_seq`

## Requirements
- R1: After reset every reset output (`*_rst_o`, high = held in reset) is high, both clock enables are low, and `app_rst_o`, `link_train_en_o`, `done_o` and `err_o` are low.
- R2: Bring-up releases the power reset first and the hot reset second. The PHY reset is released only after a tick has sampled `phy_rst_req` low.
- R3: The application clock enable rises before the reference clock enable, one step apart, and both rise after the PHY reset release.
- R4: After both clocks run, the PIPE reset is released only after a tick has sampled `core_rst_req` low. The core reset is released one step later.
- R5: After the core reset release, `app_rst_o` is high for exactly one clock, and the sticky reset is still held during that clock.
- R6: The sticky reset, the non-sticky reset and the peripheral reset are then released in that order. `done_o` rises after `RUN_US` further ticks.
- R7: A handshake wait samples its request only on `us_tick`. It fails on the `REQ_TMO_US`-th tick that sees the request still high, and not earlier.
- R8: On a failure the completed steps are undone in reverse order, one per clock. `err_o` then rises with every output back at its R1 value.
- R9: A `stop` makes all outputs take their R1 values on the next clock, without touching `app_rst_o`. A new `start` is accepted only after `STOP_US` ticks.
- R10: `link_train_en_o` stays low during the whole bring-up and is high only together with `done_o`.
- R11: A `start` outside idle is ignored. `err_o` stays high until a `stop`.
- R12: A `start` and a `stop` in the same cycle act as a stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin bring-up (idle only) |
| stop | input | 1 | Shut everything down |
| phy_rst_req | input | 1 | Power manager still requests PHY reset |
| core_rst_req | input | 1 | Power manager still requests core reset |
| us_tick | input | 1 | One-clock strobe every microsecond |
| pwr_rst_o | output | 1 | Power reset, high = asserted |
| hot_rst_o | output | 1 | Hot reset, high = asserted |
| phy_rst_o | output | 1 | PHY reset, high = asserted |
| app_clk_en_o | output | 1 | Application clock group enable |
| ref_clk_en_o | output | 1 | Reference/core clock enable |
| pipe_rst_o | output | 1 | PIPE interface reset, high = asserted |
| core_rst_o | output | 1 | Controller core reset, high = asserted |
| app_rst_o | output | 1 | One-clock application-domain reset trigger |
| sticky_rst_o | output | 1 | Sticky register reset, high = asserted |
| nsticky_rst_o | output | 1 | Non-sticky register reset, high = asserted |
| periph_rst_o | output | 1 | Peripheral (bus device) reset, high = asserted |
| link_train_en_o | output | 1 | Link-training enable |
| done_o | output | 1 | Bring-up complete |
| err_o | output | 1 | Bring-up failed, sticky until stop |

## Verification
Two pairs of events can fall in the same cycle.
- `start` and `stop` together in idle. The bench raises both in one cycle, with `start` first in priority order, and judges the result two ways. No output may move, and a second `start` given shortly afterwards must still be ignored, because the block has to sit in its stop hold.
- A `stop` during a handshake wait or during the failed state. It has to override the wait's own pass or timeout decision, and it must collapse the outputs in a single change instead of a step-by-step unwind.

A scoreboard compares every output change against the expected order, so any extra intermediate step shows up as a mismatch.

// File: rtl/pwrup_pkg.sv
package pwrup_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_STEP,
        S_WAIT_PHY,
        S_WAIT_CORE,
        S_APP_PULSE,
        S_SETTLE,
        S_READY,
        S_UNWIND,
        S_FAIL,
        S_STOP
    } seq_state_e;

    // number of level steps in the bring-up chain
    localparam int unsigned NUM_STEPS = 10;
    localparam int unsigned LVL_W     = $clog2(NUM_STEPS + 1);

    // index into the "released" vector: step k complete <=> released[k-1]
    localparam int unsigned IX_PWR    = 0;
    localparam int unsigned IX_HOT    = 1;
    localparam int unsigned IX_PHY    = 2;
    localparam int unsigned IX_APPCLK = 3;
    localparam int unsigned IX_REFCLK = 4;
    localparam int unsigned IX_PIPE   = 5;
    localparam int unsigned IX_CORE   = 6;
    localparam int unsigned IX_STICKY = 7;
    localparam int unsigned IX_NSTKY  = 8;
    localparam int unsigned IX_PERIPH = 9;

    // levels at which the sequence leaves the plain stepping state
    localparam logic [LVL_W-1:0] LV_PHY_WAIT  = LVL_W'(IX_HOT + 1);
    localparam logic [LVL_W-1:0] LV_CORE_WAIT = LVL_W'(IX_REFCLK + 1);
    localparam logic [LVL_W-1:0] LV_PULSE     = LVL_W'(IX_CORE + 1);
    localparam logic [LVL_W-1:0] LV_LAST      = LVL_W'(NUM_STEPS);

endpackage

// File: rtl/pwrup_tick_timer.sv
module pwrup_tick_timer #(
    parameter int unsigned TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          run,
    input  logic          tick,
    input  logic [TW-1:0] limit,
    output logic          expire
);

    logic [TW-1:0] cnt_q;

    assign expire = run && tick && (cnt_q == limit - 1'b1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (run && tick && !expire) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R7: the tick count of a running window never reaches its limit
    p_cnt_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt_q < limit));

endmodule

// File: rtl/pwrup_fsm.sv
module pwrup_fsm
    import pwrup_pkg::*;
#(
    parameter int unsigned REQ_TMO_US = 1000,
    parameter int unsigned RUN_US     = 100,
    parameter int unsigned STOP_US    = 100000,
    parameter int unsigned TW         = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             stop,
    input  logic             phy_req,
    input  logic             core_req,
    input  logic             tick,
    input  logic             expire,
    output seq_state_e       state_o,
    output logic [LVL_W-1:0] lvl_o,
    output logic             tmr_clr,
    output logic             tmr_run,
    output logic [TW-1:0]    tmr_limit
);

    seq_state_e       state_q, state_d;
    logic [LVL_W-1:0] lvl_q, lvl_d;

    // next-state and next-level decision
    always_comb begin
        state_d = state_q;
        lvl_d   = lvl_q;
        if (stop && state_q != S_STOP) begin
            state_d = S_STOP;
            lvl_d   = '0;
        end else begin
            unique case (state_q)
                S_IDLE: begin
                    if (start) begin
                        state_d = S_STEP;
                        lvl_d   = LVL_W'(1);
                    end
                end
                S_STEP: begin
                    if (lvl_q == LV_PHY_WAIT) begin
                        state_d = S_WAIT_PHY;
                    end else if (lvl_q == LV_CORE_WAIT) begin
                        state_d = S_WAIT_CORE;
                    end else if (lvl_q == LV_PULSE) begin
                        state_d = S_APP_PULSE;
                    end else if (lvl_q == LV_LAST) begin
                        state_d = S_SETTLE;
                    end else begin
                        lvl_d = lvl_q + 1'b1;
                    end
                end
                S_WAIT_PHY: begin
                    if (tick && !phy_req) begin
                        state_d = S_STEP;
                        lvl_d   = lvl_q + 1'b1;
                    end else if (expire) begin
                        state_d = S_UNWIND;
                    end
                end
                S_WAIT_CORE: begin
                    if (tick && !core_req) begin
                        state_d = S_STEP;
                        lvl_d   = lvl_q + 1'b1;
                    end else if (expire) begin
                        state_d = S_UNWIND;
                    end
                end
                S_APP_PULSE: begin
                    state_d = S_STEP;
                    lvl_d   = lvl_q + 1'b1;
                end
                S_SETTLE: begin
                    if (expire) state_d = S_READY;
                end
                S_READY: begin
                    state_d = S_READY;
                end
                S_UNWIND: begin
                    if (lvl_q == '0) state_d = S_FAIL;
                    else             lvl_d   = lvl_q - 1'b1;
                end
                S_FAIL: begin
                    state_d = S_FAIL;
                end
                S_STOP: begin
                    if (expire) state_d = S_IDLE;
                end
                default: begin
                    state_d = S_IDLE;
                    lvl_d   = '0;
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            lvl_q   <= '0;
        end else begin
            state_q <= state_d;
            lvl_q   <= lvl_d;
        end
    end

    // timer control
    always_comb begin
        tmr_clr = (state_d != state_q);
        tmr_run = 1'b0;
        tmr_limit = TW'(1);
        case (state_q)
            S_WAIT_PHY, S_WAIT_CORE: begin
                tmr_run   = 1'b1;
                tmr_limit = TW'(REQ_TMO_US);
            end
            S_SETTLE: begin
                tmr_run   = 1'b1;
                tmr_limit = TW'(RUN_US);
            end
            S_STOP: begin
                tmr_run   = 1'b1;
                tmr_limit = TW'(STOP_US);
            end
            default: ;
        endcase
    end

    assign state_o = state_q;
    assign lvl_o   = lvl_q;

    // R7: between ticks a wait neither advances nor changes state
    p_wait_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == S_WAIT_PHY || state_q == S_WAIT_CORE) && !tick && !stop)
        |=> (state_q == $past(state_q)) && $stable(lvl_q));

    // R8: unwinding removes exactly one step per clock
    p_unwind_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_UNWIND && lvl_q != '0 && !stop)
        |=> (lvl_q == $past(lvl_q) - 1'b1));

    // R8: the failed state holds no completed step
    p_fail_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_FAIL) |-> (lvl_q == '0));

    // R11: a start outside idle leaves state and level unchanged
    p_start_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !stop && (state_q == S_READY || state_q == S_FAIL))
        |=> (state_q == $past(state_q)) && $stable(lvl_q));

endmodule

// File: rtl/pwrup_out_map.sv
module pwrup_out_map
    import pwrup_pkg::*;
(
    input  seq_state_e       state_i,
    input  logic [LVL_W-1:0] lvl_i,
    output logic             pwr_rst_o,
    output logic             hot_rst_o,
    output logic             phy_rst_o,
    output logic             app_clk_en_o,
    output logic             ref_clk_en_o,
    output logic             pipe_rst_o,
    output logic             core_rst_o,
    output logic             app_rst_o,
    output logic             sticky_rst_o,
    output logic             nsticky_rst_o,
    output logic             periph_rst_o,
    output logic             link_train_en_o,
    output logic             done_o,
    output logic             err_o
);

    logic [NUM_STEPS-1:0] released;

    for (genvar i = 0; i < NUM_STEPS; i++) begin : g_rel
        assign released[i] = (lvl_i > LVL_W'(i));
    end

    always_comb begin
        pwr_rst_o       = !released[IX_PWR];
        hot_rst_o       = !released[IX_HOT];
        phy_rst_o       = !released[IX_PHY];
        app_clk_en_o    =  released[IX_APPCLK];
        ref_clk_en_o    =  released[IX_REFCLK];
        pipe_rst_o      = !released[IX_PIPE];
        core_rst_o      = !released[IX_CORE];
        sticky_rst_o    = !released[IX_STICKY];
        nsticky_rst_o   = !released[IX_NSTKY];
        periph_rst_o    = !released[IX_PERIPH];
        app_rst_o       = (state_i == S_APP_PULSE);
        link_train_en_o = (state_i == S_READY);
        done_o          = (state_i == S_READY);
        err_o           = (state_i == S_FAIL);
    end

endmodule

// File: rtl/pwrup_rst_seq.sv
module pwrup_rst_seq
    import pwrup_pkg::*;
#(
    parameter int unsigned REQ_TMO_US = 1000,
    parameter int unsigned RUN_US     = 100,
    parameter int unsigned STOP_US    = 100000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic stop,
    input  logic phy_rst_req,
    input  logic core_rst_req,
    input  logic us_tick,
    output logic pwr_rst_o,
    output logic hot_rst_o,
    output logic phy_rst_o,
    output logic app_clk_en_o,
    output logic ref_clk_en_o,
    output logic pipe_rst_o,
    output logic core_rst_o,
    output logic app_rst_o,
    output logic sticky_rst_o,
    output logic nsticky_rst_o,
    output logic periph_rst_o,
    output logic link_train_en_o,
    output logic done_o,
    output logic err_o
);

    localparam int unsigned MAX_A = (REQ_TMO_US > RUN_US) ? REQ_TMO_US : RUN_US;
    localparam int unsigned MAX_L = (MAX_A > STOP_US) ? MAX_A : STOP_US;
    localparam int unsigned TW    = $clog2(MAX_L + 1);

    seq_state_e       state;
    logic [LVL_W-1:0] lvl;
    logic             tmr_clr, tmr_run, tmr_exp;
    logic [TW-1:0]    tmr_limit;

    pwrup_fsm #(
        .REQ_TMO_US (REQ_TMO_US),
        .RUN_US     (RUN_US),
        .STOP_US    (STOP_US),
        .TW         (TW)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .stop      (stop),
        .phy_req   (phy_rst_req),
        .core_req  (core_rst_req),
        .tick      (us_tick),
        .expire    (tmr_exp),
        .state_o   (state),
        .lvl_o     (lvl),
        .tmr_clr   (tmr_clr),
        .tmr_run   (tmr_run),
        .tmr_limit (tmr_limit)
    );

    pwrup_tick_timer #(
        .TW (TW)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (tmr_clr),
        .run    (tmr_run),
        .tick   (us_tick),
        .limit  (tmr_limit),
        .expire (tmr_exp)
    );

    pwrup_out_map u_map (
        .state_i         (state),
        .lvl_i           (lvl),
        .pwr_rst_o       (pwr_rst_o),
        .hot_rst_o       (hot_rst_o),
        .phy_rst_o       (phy_rst_o),
        .app_clk_en_o    (app_clk_en_o),
        .ref_clk_en_o    (ref_clk_en_o),
        .pipe_rst_o      (pipe_rst_o),
        .core_rst_o      (core_rst_o),
        .app_rst_o       (app_rst_o),
        .sticky_rst_o    (sticky_rst_o),
        .nsticky_rst_o   (nsticky_rst_o),
        .periph_rst_o    (periph_rst_o),
        .link_train_en_o (link_train_en_o),
        .done_o          (done_o),
        .err_o           (err_o)
    );

    // R1: first cycle after reset release shows the quiescent outputs
    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> pwr_rst_o && periph_rst_o && !app_clk_en_o
                          && !ref_clk_en_o && !done_o && !err_o && !link_train_en_o);

    // R2: PHY reset released only after a low PHY request and the hot release
    p_phy_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(phy_rst_o) |-> $past(!phy_rst_req) && !hot_rst_o && !pwr_rst_o);

    // R3: reference clock starts only with the application clock already on
    p_clk_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ref_clk_en_o) |-> $past(app_clk_en_o) && !phy_rst_o);

    // R4: PIPE release needs a low core request; core release follows PIPE
    p_pipe_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pipe_rst_o) |-> $past(!core_rst_req) && ref_clk_en_o);
    p_core_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(core_rst_o) |-> $past(!pipe_rst_o));

    // R5: application reset is a single-clock pulse between core and sticky release
    p_app_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        app_rst_o |=> !app_rst_o);
    p_app_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
        app_rst_o |-> !core_rst_o && sticky_rst_o);

    // R6: register resets and peripheral reset leave in order
    p_nsticky_order_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(nsticky_rst_o) |-> $past(!sticky_rst_o));
    p_periph_order_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(periph_rst_o) |-> $past(!nsticky_rst_o));

    // R8: the error flag rises with everything back down
    p_err_down_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_o) |-> pwr_rst_o && phy_rst_o && !app_clk_en_o && periph_rst_o);

    // R9: one clock after a stop every output is in its quiescent value
    p_stop_down_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(stop)) |-> pwr_rst_o && hot_rst_o && phy_rst_o
            && pipe_rst_o && core_rst_o && sticky_rst_o && nsticky_rst_o
            && periph_rst_o && !app_clk_en_o && !ref_clk_en_o && !app_rst_o
            && !link_train_en_o && !done_o && !err_o);

    // R10: link training only with the peripheral reset released
    p_link_late_r10: assert property (@(posedge clk) disable iff (!rst_n)
        link_train_en_o |-> !periph_rst_o && !nsticky_rst_o);

    // R11: error stays until a stop
    p_err_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (err_o && !stop) |=> err_o);

    // R12: start together with stop never starts a bring-up
    p_stop_wins_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (start && stop) |=> pwr_rst_o);

endmodule

// File: tb/pwrup_rst_seq_test.sv
module pwrup_rst_seq_test;

    localparam int CLK_PERIOD = 10;
    localparam int TICK_DIV   = 4;
    localparam int TMO        = 20;
    localparam int RUN        = 5;
    localparam int HOLD       = 8;

    logic clk = 1'b0, rst_n = 1'b0;
    logic start = 1'b0, stop = 1'b0, phy_req = 1'b0, core_req = 1'b0, tick = 1'b0;
    logic pwr, hot, phy, appclk, refclk, pipe, core, apprst, sticky, nstky, periph, link, done, err;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    logic [13:0] expq[$];
    string       tagq[$];

    pwrup_rst_seq #(.REQ_TMO_US(TMO), .RUN_US(RUN), .STOP_US(HOLD)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .stop(stop),
        .phy_rst_req(phy_req), .core_rst_req(core_req), .us_tick(tick),
        .pwr_rst_o(pwr), .hot_rst_o(hot), .phy_rst_o(phy),
        .app_clk_en_o(appclk), .ref_clk_en_o(refclk), .pipe_rst_o(pipe),
        .core_rst_o(core), .app_rst_o(apprst), .sticky_rst_o(sticky),
        .nsticky_rst_o(nstky), .periph_rst_o(periph),
        .link_train_en_o(link), .done_o(done), .err_o(err)
    );

    wire [13:0] obs = {pwr, hot, phy, appclk, refclk, pipe, core, apprst,
                       sticky, nstky, periph, link, done, err};

    always #(CLK_PERIOD/2) clk = ~clk;

    // microsecond strobe, changed away from the active edge
    initial begin
        int divc = 0;
        forever begin
            @(negedge clk);
            divc++;
            tick = (divc % TICK_DIV == 0);
        end
    end

    // expected output vector for a progress level, from the requirements
    function automatic logic [13:0] expv(int lvl, bit pulse, bit rdy, bit er);
        logic [13:0] v;
        v[13] = (lvl < 1);  v[12] = (lvl < 2);  v[11] = (lvl < 3);
        v[10] = (lvl >= 4); v[9]  = (lvl >= 5); v[8]  = (lvl < 6);
        v[7]  = (lvl < 7);  v[6]  = pulse;      v[5]  = (lvl < 8);
        v[4]  = (lvl < 9);  v[3]  = (lvl < 10); v[2]  = rdy;
        v[1]  = rdy;        v[0]  = er;
        return v;
    endfunction

    function automatic string lvl_tag(int lvl);
        if (lvl <= 3)      return "R2";
        else if (lvl <= 5) return "R3";
        else if (lvl <= 7) return "R4";
        else               return "R6";
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // driver side of the scoreboard
    task automatic push(logic [13:0] v, string tag);
        expq.push_back(v);
        tagq.push_back(tag);
    endtask

    task automatic push_run(int from);
        for (int l = from; l <= 10; l++) begin
            push(expv(l, 0, 0, 0), lvl_tag(l));
            if (l == 7) push(expv(7, 1, 0, 0), "R5");
        end
        push(expv(10, 0, 1, 0), "R10");
    endtask

    task automatic push_unwind(int from);
        for (int l = from - 1; l >= 0; l--) push(expv(l, 0, 0, 0), "R8");
        push(expv(0, 0, 0, 1), "R8");
    endtask

    task automatic pulse_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic pulse_stop();
        @(negedge clk); stop = 1'b1;
        @(negedge clk); stop = 1'b0;
    endtask

    task automatic wait_ticks(int n);
        int k = 0;
        while (k < n) begin
            @(posedge clk);
            if (tick) k++;
        end
    endtask

    task automatic drain(string tag);
        @(negedge clk);
        check(tag, expq.size(), 0);
    endtask

    // monitor side of the scoreboard
    initial begin
        logic [13:0] prev;
        @(posedge rst_n);
        @(negedge clk);
        prev = obs;
        forever begin
            @(negedge clk);
            if (obs !== prev) begin
                if (expq.size() == 0) begin
                    checks++;
                    errors++;
                    $display("FAIL unexpected change R11 actual=%0h expected=%0h", obs, prev);
                end else begin
                    logic [13:0] e;
                    string t;
                    e = expq.pop_front();
                    t = tagq.pop_front();
                    check(t, obs, e);
                end
            end
            prev = obs;
        end
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog R1 actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int n;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset outputs", obs, expv(0, 0, 0, 0));

        // full bring-up, requests already low
        push_run(1);
        pulse_start();
        while (1) begin @(posedge clk); #1; if (!periph) break; end
        n = 0;
        while (1) begin
            logic t;
            @(posedge clk); t = tick; #1;
            if (done) break;
            if (t) n++;
        end
        check("R6 settle ticks in range", (n >= RUN - 1 && n <= RUN), 1);
        drain("R6 order complete");
        check("R10 link with done", {link, done}, 2'b11);

        // start while ready is ignored
        pulse_start();
        wait_ticks(10);
        @(negedge clk);
        check("R11 start in ready ignored", obs, expv(10, 0, 1, 0));

        // stop from ready, start during hold ignored
        push(expv(0, 0, 0, 0), "R9");
        pulse_stop();
        @(negedge clk);
        check("R9 stop collapses outputs", obs, expv(0, 0, 0, 0));
        wait_ticks(2);
        pulse_start();
        wait_ticks(3);
        @(negedge clk);
        check("R9 start during hold ignored", obs, expv(0, 0, 0, 0));
        wait_ticks(HOLD + 2);
        drain("R9 single change");

        // PHY request held for a while, then cleared
        phy_req = 1'b1;
        push(expv(1, 0, 0, 0), "R2");
        push(expv(2, 0, 0, 0), "R2");
        pulse_start();
        wait_ticks(8);
        @(negedge clk);
        check("R2 PHY held while requested", phy, 1);
        check("R7 no early timeout", err, 0);
        push_run(3);
        phy_req = 1'b0;
        wait_ticks(RUN + 15);
        @(negedge clk);
        check("R2 bring-up after request clears", done, 1);
        drain("R2 order complete");
        push(expv(0, 0, 0, 0), "R9");
        pulse_stop();
        wait_ticks(HOLD + 3);
        drain("R9 stop after wait");

        // core request never clears: timeout and unwind
        core_req = 1'b1;
        for (int l = 1; l <= 5; l++) push(expv(l, 0, 0, 0), lvl_tag(l));
        push_unwind(5);
        pulse_start();
        wait_ticks(12);
        @(negedge clk);
        check("R7 core wait not yet failed", err, 0);
        check("R4 PIPE held while requested", pipe, 1);
        wait_ticks(15);
        @(negedge clk);
        check("R7 core timeout flags error", err, 1);
        check("R8 error with all down", obs, expv(0, 0, 0, 1));
        drain("R8 reverse order");
        pulse_start();
        wait_ticks(5);
        @(negedge clk);
        check("R11 error sticky across start", obs, expv(0, 0, 0, 1));
        push(expv(0, 0, 0, 0), "R11");
        pulse_stop();
        @(negedge clk);
        check("R11 stop clears error", err, 0);
        wait_ticks(HOLD + 3);
        core_req = 1'b0;
        drain("R11 clear");

        // PHY request never clears
        phy_req = 1'b1;
        push(expv(1, 0, 0, 0), "R2");
        push(expv(2, 0, 0, 0), "R2");
        push_unwind(2);
        pulse_start();
        wait_ticks(TMO + 8);
        @(negedge clk);
        check("R7 PHY timeout", obs, expv(0, 0, 0, 1));
        drain("R8 PHY unwind");
        push(expv(0, 0, 0, 0), "R9");
        pulse_stop();
        wait_ticks(HOLD + 3);
        drain("R9 after PHY fail");

        // stop in the middle of a wait: one change, no unwind
        push(expv(1, 0, 0, 0), "R2");
        push(expv(2, 0, 0, 0), "R2");
        pulse_start();
        wait_ticks(5);
        push(expv(0, 0, 0, 0), "R9");
        pulse_stop();
        @(negedge clk);
        check("R9 stop mid bring-up", obs, expv(0, 0, 0, 0));
        check("R9 no app pulse on stop", apprst, 0);
        wait_ticks(HOLD + 3);
        phy_req = 1'b0;
        drain("R9 mid stop single change");

        // start and stop in the same cycle
        @(negedge clk); start = 1'b1; stop = 1'b1;
        @(negedge clk); start = 1'b0; stop = 1'b0;
        wait_ticks(1);
        pulse_start();
        wait_ticks(3);
        @(negedge clk);
        check("R12 stop wins, hold active", obs, expv(0, 0, 0, 0));
        wait_ticks(HOLD + 2);
        push_run(1);
        pulse_start();
        wait_ticks(RUN + 20);
        @(negedge clk);
        check("R12 start accepted after hold", done, 1);
        drain("R12 order complete");

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule